// File: doc/BRIEF.md
# Memory Operation Fence Gate

This block sits between the unit that issues memory operations and the memory pipeline behind it. Every cycle it looks at the operation offered for issue: its kind (load, store, word swap or byte swap), the three page attribute bits X, C and B of its page, and whether address translation is enabled. From these it decides whether the operation must act as an ordering barrier. It also counts the operations that have been issued but have not yet reported completion.

A barrier operation may only start once every operation issued before it has completed. Until the barrier's own completion comes back, nothing issued after it may start. Ordinary operations are not reordered or held by the gate. They only have to wait for room in the outstanding count or for a pending barrier. The gate is the only thing that drives the issue-ready signal. An operation issues in every cycle in which it is offered and ready is high.

Top module: `fence_gate`

## Requirements
- R1: After synchronous reset, no operations are outstanding and no barrier is pending, so any offered operation sees issue_ready high.
- R2: With translation on (mmu_on=1), a load (op_kind=2'b00) whose C bit is 0 is a barrier, whatever X and B are. A load with C=1 is not a barrier.
- R3: With translation on, a store (op_kind=2'b01) is a barrier only for {X,C,B}=3'b101 or 3'b000. Every other store encoding is ordinary.
- R4: A swap (op_kind=2'b10 word, 2'b11 byte) is a barrier when its attributes would make either a load or a store a barrier under R2 or R3.
- R5: With translation off (mmu_on=0), every operation is a barrier, regardless of its attribute bits.
- R6: A barrier is ready only while the registered outstanding count is zero. A completion arriving in the same cycle does not release it until the next cycle.
- R7: Once a barrier issues, issue_ready stays low for every operation until the next completion strobe, which is the barrier's own.
- R8: Ordinary operations issue while others are outstanding, up to DEPTH outstanding. When DEPTH are outstanding, issue_ready is low.
- R9: An issue and a completion in the same cycle leave the outstanding count unchanged. A completion while nothing is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered for issue |
| op_kind | input | 2 | 00 load, 01 store, 10 word swap, 11 byte swap |
| attr_x | input | 1 | Page attribute X |
| attr_c | input | 1 | Page attribute C |
| attr_b | input | 1 | Page attribute B |
| mmu_on | input | 1 | Translation enabled; when low, attributes read as zero |
| cpl_valid | input | 1 | One previously issued operation has completed |
| issue_ready | output | 1 | The offered operation may issue this cycle |

## Verification
The assertions check several properties on every cycle. The outstanding count never passes DEPTH, and ready is low at full. A barrier only fires with the count at zero, and ready is low in the cycle after a barrier fires. A simultaneous issue and completion leaves the count unchanged, and ready is low with translation off while anything is outstanding. The decode of each attribute encoding for each operation kind, and the release of the block by the barrier's own completion, can only be shown by the bench's scenarios. There, a behavioural model tracks count and pending state and is compared with issue_ready on every cycle.

// File: rtl/fence_gate_pkg.sv
package fence_gate_pkg;
  typedef enum logic [1:0] {
    OPK_LOAD   = 2'b00,
    OPK_STORE  = 2'b01,
    OPK_SWAP_W = 2'b10,
    OPK_SWAP_B = 2'b11
  } opk_e;

  typedef struct packed {
    logic x;
    logic c;
    logic b;
  } page_attr_t;
endpackage

// File: rtl/fence_classify.sv
module fence_classify
  import fence_gate_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       ax,
  input  logic       ac,
  input  logic       ab,
  input  logic       xlat_on,
  output logic       barrier
);
  page_attr_t eff;
  logic load_rule;
  logic store_rule;
  opk_e k;

  // With translation off the attributes behave as all zero.
  always_comb begin
    eff.x = ax & xlat_on;
    eff.c = ac & xlat_on;
    eff.b = ab & xlat_on;
  end

  always_comb begin
    k          = opk_e'(kind);
    load_rule  = ~eff.c;
    store_rule = (~eff.c) & (eff.x ~^ eff.b);
    case (k)
      OPK_LOAD:   barrier = load_rule;
      OPK_STORE:  barrier = store_rule;
      OPK_SWAP_W,
      OPK_SWAP_B: barrier = load_rule | store_rule;
      default:    barrier = 1'b1;
    endcase
  end
endmodule

// File: rtl/outstanding_ctr.sv
module outstanding_ctr #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          empty,
  output logic          full
);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  logic do_inc;
  logic do_dec;

  assign empty  = (cnt == '0);
  assign full   = (cnt == TOP);
  assign do_inc = inc & ~full;
  assign do_dec = dec & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (do_inc && !do_dec) begin
      cnt <= cnt + 1'b1;
    end else if (do_dec && !do_inc) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fence_ctrl.sv
module fence_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic offer,
  input  logic barrier,
  input  logic empty,
  input  logic full,
  input  logic cpl,
  output logic ready,
  output logic fire
);
  logic pend;

  assign ready = ~pend & ~full & (~barrier | empty);
  assign fire  = offer & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (fire && barrier) begin
      pend <= 1'b1;
    end else if (cpl) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/fence_gate.sv
module fence_gate #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  input  logic       attr_x,
  input  logic       attr_c,
  input  logic       attr_b,
  input  logic       mmu_on,
  input  logic       cpl_valid,
  output logic       issue_ready
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          is_fence;
  logic          fire;
  logic [CW-1:0] out_cnt;
  logic          cnt_empty;
  logic          cnt_full;

  fence_classify u_cls (
    .kind    (op_kind),
    .ax      (attr_x),
    .ac      (attr_c),
    .ab      (attr_b),
    .xlat_on (mmu_on),
    .barrier (is_fence)
  );

  outstanding_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .inc   (fire),
    .dec   (cpl_valid),
    .cnt   (out_cnt),
    .empty (cnt_empty),
    .full  (cnt_full)
  );

  fence_ctrl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .offer   (op_valid),
    .barrier (is_fence),
    .empty   (cnt_empty),
    .full    (cnt_full),
    .cpl     (cpl_valid),
    .ready   (issue_ready),
    .fire    (fire)
  );
endmodule

// File: rtl/fence_gate_chk.sv
module fence_gate_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_ready,
  input logic          fire,
  input logic          is_fence,
  input logic [CW-1:0] cnt,
  input logic          mmu_on,
  input logic          cpl
);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);

  a_r8_full_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |-> !issue_ready);

  a_r6_fence_on_empty: assert property (@(posedge clk) disable iff (rst)
    (fire && is_fence) |-> (cnt == '0));

  a_r7_block_after_fence: assert property (@(posedge clk) disable iff (rst)
    (fire && is_fence) |=> !issue_ready);

  a_r9_same_cycle_stable: assert property (@(posedge clk) disable iff (rst)
    (fire && cpl && cnt != '0) |=> $stable(cnt));

  a_r5_off_all_fence: assert property (@(posedge clk) disable iff (rst)
    (!mmu_on && cnt != '0) |-> !issue_ready);
endmodule

bind fence_gate fence_gate_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_ready (issue_ready),
  .fire        (fire),
  .is_fence    (is_fence),
  .cnt         (out_cnt),
  .mmu_on      (mmu_on),
  .cpl         (cpl_valid)
);

// File: tb/fence_gate_bench.sv
module fence_gate_bench;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic       attr_x = 1'b0, attr_c = 1'b0, attr_b = 1'b0;
  logic       mmu_on = 1'b1;
  logic       cpl_valid = 1'b0;
  logic       issue_ready;

  int vectors = 0;
  int errors  = 0;
  int m_cnt   = 0;
  bit m_pend  = 0;

  always #2.5 clk = ~clk;

  fence_gate #(.DEPTH(DEPTH)) u_fence_gate (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .attr_x(attr_x), .attr_c(attr_c), .attr_b(attr_b), .mmu_on(mmu_on),
    .cpl_valid(cpl_valid), .issue_ready(issue_ready)
  );

  // Barrier decision written straight from R2..R5.
  function automatic bit want_fence(input logic [1:0] k, input bit x, input bit c,
                                     input bit b, input bit m);
    bit ld, st;
    if (!m) return 1'b1;                                          // R5
    ld = (c == 1'b0);                                             // R2
    st = ({x, c, b} == 3'b101) || ({x, c, b} == 3'b000);          // R3
    if (k == 2'b00) return ld;
    if (k == 2'b01) return st;
    return ld || st;                                              // R4
  endfunction

  task automatic step(input bit v, input logic [1:0] k, input bit x, input bit c,
                      input bit b, input bit m, input bit cp, input string tag);
    bit exp_rdy, f;
    @(negedge clk);
    op_valid = v; op_kind = k; attr_x = x; attr_c = c; attr_b = b;
    mmu_on = m; cpl_valid = cp;
    #1;
    f = want_fence(k, x, c, b, m);
    exp_rdy = !m_pend && (m_cnt < DEPTH) && (!f || m_cnt == 0);
    vectors++;
    if (issue_ready !== exp_rdy) begin
      errors++;
      $display("FAIL %s: issue_ready=%b expected %b (count %0d pend %0b)",
               tag, issue_ready, exp_rdy, m_cnt, m_pend);
    end
    @(posedge clk);
    if (v && exp_rdy && f) m_pend = 1'b1;
    else if (cp) m_pend = 1'b0;
    if (v && exp_rdy && !(cp && m_cnt > 0)) m_cnt++;
    else if (cp && m_cnt > 0 && !(v && exp_rdy)) m_cnt--;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: fence offered right after reset is ready
    step(0, 2'b00, 0, 0, 0, 0, 0, "R1");
    step(1, 2'b01, 1, 1, 1, 1, 0, "R1");
    // fill with ordinary ops to full (R8)
    for (int i = 0; i < DEPTH + 2; i++) step(1, 2'b00, 0, 1, 1, 1, 0, "R8");
    // R9: drain one, then issue+complete in same cycle, then ignore-at-empty later
    step(0, 2'b00, 0, 1, 1, 1, 1, "R9");
    step(1, 2'b00, 0, 1, 0, 1, 1, "R9");
    step(1, 2'b01, 1, 1, 0, 1, 0, "R9");
    step(1, 2'b01, 0, 1, 1, 1, 0, "R8");
    // R2: load with C=0 held while outstanding, drains, then issues
    for (int i = 0; i < DEPTH + 1; i++) step(1, 2'b00, 1, 0, 1, 1, 1, "R2");
    // R7: block after fence until completion
    step(1, 2'b00, 0, 1, 1, 1, 0, "R7");
    step(1, 2'b01, 0, 1, 1, 1, 0, "R7");
    step(1, 2'b00, 0, 1, 1, 1, 1, "R7");
    step(1, 2'b00, 0, 1, 1, 1, 0, "R7");
    // R3 / R4: every encoding with one outstanding op
    for (int kk = 1; kk < 4; kk++)
      for (int a = 0; a < 8; a++) begin
        step(0, 2'(kk), a[2], a[1], a[0], 1, 0, kk == 1 ? "R3" : "R4");
        step(1, 2'(kk), a[2], a[1], a[0], 1, 0, kk == 1 ? "R3" : "R4");
        step(0, 2'b00, 0, 1, 1, 1, 1, "R6");
        if (m_cnt > 1) step(0, 2'b00, 0, 1, 1, 1, 1, "R6");
      end
    // R5: translation off turns cacheable ops into fences
    step(1, 2'b00, 0, 1, 1, 1, 0, "R5");
    step(1, 2'b00, 1, 1, 1, 0, 0, "R5");
    step(1, 2'b01, 1, 1, 1, 0, 1, "R6");
    step(1, 2'b01, 1, 1, 1, 0, 0, "R5");
    step(1, 2'b10, 1, 1, 1, 0, 1, "R5");
    // R9: completions with nothing outstanding are ignored
    for (int i = 0; i < 3; i++) step(0, 2'b00, 0, 1, 1, 1, 1, "R9");
    step(1, 2'b00, 0, 0, 0, 1, 0, "R9");
    step(1, 2'b00, 0, 1, 1, 1, 1, "R9");
    // mixed traffic
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)), $urandom_range(0, 7) != 0,
           $urandom_range(0, 2) == 0, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule